// File: doc/BRIEF.md
# Power-State LED Behaviour Controller

This block drives two indicator LED outputs. Three things set their levels: a 2-bit mode selector, the system's current power and sleep condition, and a 2-bit software setting for each LED. Two supply-present flags give the power condition: one for the standby supply and one for the main supply. Two sleep flags mark suspend-to-RAM and suspend-to-disk/soft-off. The mode selects which of these conditions may override the software setting of each LED.

A single free-running divider runs from the slow crystal clock and produces every blink waveform. A "second" is 2^DIV_BITS clock cycles, which is 32768 cycles with the default. Both LEDs take their timing from this divider, so they always blink in phase. Each output is registered, so a change of mode, supply or setting cannot put a glitch on the pins.

Top module: `led_power_ctrl`

## Requirements
- R1: In every mode, with both `sb_ok` and `main_ok` low, both LED outputs are low one clock later.
- R2: In mode 2'b00, while either supply is present, each LED follows only its own setting. The sleep flags and the supply combination have no effect.
- R3: In mode 2'b01, with `sb_ok` high and `main_ok` low, both LEDs blink together at one blink per second. Each is high for the first half of every second, and the software settings are ignored.
- R4: In mode 2'b01, with both supplies present, each LED follows its own setting.
- R5: In mode 2'b10, with `slp_off` high and at least one supply present, both LEDs are low.
- R6: In mode 2'b10, with `slp_off` low (powered on or suspend-to-RAM), each LED follows its own setting.
- R7: In mode 2'b11, while either supply is present, each LED follows its own setting in the powered-on state and in both sleep states.
- R8: The setting encoding is as follows. 2'b00 is off. 2'b01 is steady on. 2'b10 blinks at 1 Hz, high for the first half of each second. 2'b11 blinks at 0.25 Hz, high for the first of every four seconds.
- R9: While `rst_n` is low, both outputs and the divider are held at zero. From reset release the divider counts one step per clock. An output takes the value set by the inputs and the divider phase at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz clock |
| rst_n | input | 1 | Active-low reset |
| sb_ok | input | 1 | Standby supply present |
| main_ok | input | 1 | Main supply present |
| slp_ram | input | 1 | Suspend-to-RAM sleep state |
| slp_off | input | 1 | Suspend-to-disk / soft-off sleep state |
| mode | input | 2 | Override mode selector |
| cfg_a | input | 2 | Software setting, LED A |
| cfg_b | input | 2 | Software setting, LED B |
| led_a | output | 1 | LED A level, active high |
| led_b | output | 1 | LED B level, active high |

## Verification
The hardest case to reach is the slow 0.25 Hz pattern. Its whole period spans four seconds of divider time, so one full on/off cycle needs 2^(DIV_BITS+2) clocks. The bench sets DIV_BITS to 3, which makes a "second" eight clocks. It then holds each scenario for 64 clocks, which covers two full slow periods and eight fast ones. The bench counts clock edges from reset release to predict the divider phase, and it sets LED A and LED B to different encodings so that an override shows up as the two outputs matching.

// File: rtl/led_power_ctrl.sv
module led_power_ctrl #(
  parameter int DIV_BITS = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sb_ok,
  input  logic       main_ok,
  input  logic       slp_ram,
  input  logic       slp_off,
  input  logic [1:0] mode,
  input  logic [1:0] cfg_a,
  input  logic [1:0] cfg_b,
  output logic       led_a,
  output logic       led_b
);

  localparam int PW = DIV_BITS + 2;

  logic [PW-1:0] phase;

  wire fast_on = ~phase[DIV_BITS-1];
  wire slow_on = (phase[PW-1:DIV_BITS] == 2'b00);

  wire powered      = sb_ok | main_ok;
  wire standby_only = sb_ok & ~main_ok;
  wire force_blink  = (mode == 2'b01) & standby_only;
  wire force_off    = ~powered | ((mode == 2'b10) & slp_off);
  wire unused_ok    = slp_ram;

  function automatic logic sw_level(input logic [1:0] cfg, input logic f, input logic s);
    case (cfg)
      2'b00:   sw_level = 1'b0;
      2'b01:   sw_level = 1'b1;
      2'b10:   sw_level = f;
      default: sw_level = s;
    endcase
  endfunction

  wire nxt_a = force_off ? 1'b0 : force_blink ? fast_on : sw_level(cfg_a, fast_on, slow_on);
  wire nxt_b = force_off ? 1'b0 : force_blink ? fast_on : sw_level(cfg_b, fast_on, slow_on);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      led_a <= 1'b0;
      led_b <= 1'b0;
    end else begin
      phase <= phase + 1'b1;
      led_a <= nxt_a;
      led_b <= nxt_b;
    end
  end

  AST_FAIL_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (!sb_ok && !main_ok) |=> (!led_a && !led_b)); // R1

  AST_STBY_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && sb_ok && !main_ok) |=> (led_a == led_b)); // R3

  AST_SOFTOFF_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && slp_off) |=> (!led_a && !led_b)); // R5

  AST_CFG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_a == 2'b00 && !(mode == 2'b01 && sb_ok && !main_ok)) |=> !led_a); // R8

  AST_CFG_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_b == 2'b01 && (sb_ok || main_ok) && mode == 2'b11) |=> led_b); // R7

  AST_RESET_DARK: assert property (@(posedge clk)
    !rst_n |-> (!led_a && !led_b)); // R9

endmodule

// File: tb/led_power_ctrl_tb.sv
module led_power_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DB = 3;
  localparam int WIN = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sb_ok = 0, main_ok = 0, slp_ram = 0, slp_off = 0;
  logic [1:0] mode = 0, cfg_a = 0, cfg_b = 0;
  logic led_a, led_b;
  int edges = 0;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n) edges <= edges + 1;

  led_power_ctrl #(.DIV_BITS(DB)) u_dut (
    .clk(clk), .rst_n(rst_n), .sb_ok(sb_ok), .main_ok(main_ok),
    .slp_ram(slp_ram), .slp_off(slp_off), .mode(mode),
    .cfg_a(cfg_a), .cfg_b(cfg_b), .led_a(led_a), .led_b(led_b));

  function automatic logic fast_exp(int e);
    int ph = (e - 1) % (1 << (DB + 2));
    return ((ph >> (DB - 1)) & 1) == 0;
  endfunction

  function automatic logic slow_exp(int e);
    int ph = (e - 1) % (1 << (DB + 2));
    return (ph >> DB) == 0;
  endfunction

  function automatic logic sw_exp(logic [1:0] c, int e);
    if (c == 2'b00) return 1'b0;
    if (c == 2'b01) return 1'b1;
    if (c == 2'b10) return fast_exp(e);
    return slow_exp(e);
  endfunction

  task automatic check(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%b expected=%b at edge %0d", req, what, act, exp, edges);
    end
  endtask

  task automatic apply(logic s, logic m, logic r, logic o, logic [1:0] md, logic [1:0] a, logic [1:0] b);
    @(negedge clk);
    sb_ok = s; main_ok = m; slp_ram = r; slp_off = o; mode = md; cfg_a = a; cfg_b = b;
  endtask

  // kind: 0 dark, 1 forced fast blink, 2 software settings
  task automatic watch(string req, int kind);
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      if (kind == 0) begin
        check(req, led_a, 1'b0, "led_a dark");
        check(req, led_b, 1'b0, "led_b dark");
      end else if (kind == 1) begin
        check(req, led_a, fast_exp(edges), "led_a forced blink");
        check(req, led_b, fast_exp(edges), "led_b forced blink");
      end else begin
        check(req, led_a, sw_exp(cfg_a, edges), "led_a software");
        check(req, led_b, sw_exp(cfg_b, edges), "led_b software");
      end
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R9", led_a, 1'b0, "reset led_a");
    check("R9", led_b, 1'b0, "reset led_b");
    rst_n = 1'b1;
  endtask

  task automatic t_fail();
    for (int md = 0; md < 4; md++) begin
      apply(0, 0, md[0], md[1], md[1:0], 2'b01, 2'b10);
      watch("R1", 0);
    end
  endtask

  task automatic t_mode00();
    apply(1, 0, 0, 1, 2'b00, 2'b10, 2'b11);
    watch("R2", 2);
    apply(1, 1, 1, 0, 2'b00, 2'b01, 2'b10);
    watch("R2", 2);
    apply(0, 1, 0, 0, 2'b00, 2'b11, 2'b00);
    watch("R2", 2);
  endtask

  task automatic t_mode01();
    apply(1, 0, 0, 0, 2'b01, 2'b00, 2'b11);
    watch("R3", 1);
    apply(1, 1, 0, 0, 2'b01, 2'b11, 2'b01);
    watch("R4", 2);
  endtask

  task automatic t_mode10();
    apply(1, 0, 0, 1, 2'b10, 2'b01, 2'b10);
    watch("R5", 0);
    apply(1, 0, 1, 0, 2'b10, 2'b10, 2'b11);
    watch("R6", 2);
    apply(1, 1, 0, 0, 2'b10, 2'b01, 2'b00);
    watch("R6", 2);
  endtask

  task automatic t_mode11();
    apply(1, 0, 0, 1, 2'b11, 2'b11, 2'b01);
    watch("R7", 2);
    apply(1, 0, 1, 0, 2'b11, 2'b10, 2'b01);
    watch("R7", 2);
    apply(1, 1, 0, 0, 2'b11, 2'b00, 2'b10);
    watch("R8", 2);
  endtask

  task automatic t_latency();
    apply(1, 1, 0, 0, 2'b00, 2'b00, 2'b00);
    @(negedge clk);
    cfg_a = 2'b01;
    #1 check("R9", led_a, 1'b0, "no change before edge");
    @(negedge clk);
    check("R9", led_a, 1'b1, "one edge later");
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_fail();
    t_mode00();
    t_mode01();
    t_mode10();
    t_mode11();
    t_latency();
    finish_run();
  end
endmodule